// File: doc/BRIEF.md
# Fuse Array Register Controller

This block is the register front end of a one-time-programmable fuse array. A host reaches it over a plain 32-bit bus with separate read and write strobes, a byte address and write data. Most of its registers are storage that drives the fuse macro's control pins: a latched fuse address, chip enable, data strobe, trim, program, write enable, clock, test controls and so on. One register, the data-out port, is read-only. It returns the fuse word that the latched address selects.

The data-out port only shows fuse contents while chip enable, data strobe and trim are all switched on. In every other case it returns 0x000000FF. The fuse contents are fixed. Every word is all ones except two words at a parameterised location. The first holds a parameterised serial number and the word after it holds the bitwise complement of that number. Reads return their data one clock after the request, with a valid pulse.

Top module: `fuse_ctl`

## Requirements
- R1: After a synchronous active-low reset, every storage register reads 0x00000000 and `rvalid` is low.
- R2: A read strobe in one cycle gives `rvalid` high, with the read data on `rdata`, in the following cycle. With no read strobe, `rvalid` is low in the following cycle.
- R3: A write to the fuse address register (offset 0x00) keeps only the low FUSE_AW bits (default 10, mask 0x3FF). It reads back with the upper bits zero.
- R4: Data-out (offset 0x18) returns the fuse word at the latched address when bit 0 of all three enable registers is 1. The enable registers are chip enable at 0x0C, data strobe at 0x1C and trim at 0x34.
- R5: If any one of the three enable bits is 0, data-out reads 0x000000FF.
- R6: The fuse word at SERIAL_ADDR (default 0x0FC) is SERIAL. The word at SERIAL_ADDR+1 is ~SERIAL. Every other word is 0xFFFFFFFF.
- R7: Writes to data-out are ignored, and the next data-out read still returns the gated fuse value.
- R8: The other registers are plain 32-bit read/write storage that read back the last value written. They are at offsets 0x04, 0x08, 0x0C, 0x10, 0x14, 0x1C, 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34 and 0x38.
- R9: An unmapped access reads 0 and a write to it changes no register. Unmapped means an offset of 0x3C or above, or an address whose low two bits are not zero.
- R10: Only bit 0 of each enable register gates data-out. A value with bit 0 clear and every other bit set counts as disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | BUS_AW | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |

## Verification
The hardest case to reach is the serial pair in the fuse array. It is visible only when all three enables are on and the address register points at one of two specific words. The stimulus writes the enables one at a time, so that each partial combination shows the 0xFF fallback. It then steps the address across the serial word, the complement word and ordinary words. After that it writes into data-out, and into a misaligned alias of a real register, to show that neither write has any effect.

// File: rtl/fuse_ctl.sv
module fuse_ctl #(
  parameter int          BUS_AW      = 8,
  parameter int          FUSE_AW     = 10,
  parameter int unsigned SERIAL_ADDR = 'hFC,
  parameter logic [31:0] SERIAL      = 32'hA5C3_0F96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid
);
  localparam int NREG   = 15;
  localparam int ADDR_I = 0;
  localparam int CE_I   = 3;
  localparam int DOUT_I = 6;
  localparam int STB_I  = 7;
  localparam int TRIM_I = 13;
  localparam logic [FUSE_AW-1:0] SER_A = SERIAL_ADDR[FUSE_AW-1:0];
  localparam logic [FUSE_AW-1:0] SER_B = FUSE_AW'(SER_A + 1'b1);

  logic [31:0] regs_q [NREG];
  logic [31:0] rd_val;

  wire [BUS_AW-3:0]  word    = addr[BUS_AW-1:2];
  wire               mapped  = (addr[1:0] == 2'b00) && (int'(word) < NREG);
  wire               is_dout = mapped && (int'(word) == DOUT_I);
  wire [FUSE_AW-1:0] fuse_a  = regs_q[ADDR_I][FUSE_AW-1:0];
  wire               gate    = regs_q[CE_I][0] & regs_q[STB_I][0] & regs_q[TRIM_I][0];
  wire [31:0]        fuse_w  = (fuse_a == SER_A) ? SERIAL :
                               (fuse_a == SER_B) ? ~SERIAL : 32'hFFFF_FFFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en && mapped && !is_dout) begin
      for (int i = 0; i < NREG; i++)
        if (int'(word) == i)
          regs_q[i] <= (i == ADDR_I) ? {{(32-FUSE_AW){1'b0}}, wdata[FUSE_AW-1:0]} : wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (is_dout) rd_val = gate ? fuse_w : 32'h0000_00FF;
    else if (mapped)
      for (int i = 0; i < NREG; i++)
        if (int'(word) == i) rd_val = regs_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      rdata  <= rd_en ? rd_val : '0;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rdata == 32'h0));
  a_r5_gated_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_dout && !gate) |=> (rdata == 32'h0000_00FF));
  a_r3_addr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_q[ADDR_I] >> FUSE_AW) == 32'h0);
endmodule

// File: tb/test_fuse_ctl.sv
`timescale 1ns/1ps
module test_fuse_ctl;
  localparam logic [31:0] SER = 32'hA5C3_0F96;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rvalid;
  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  fuse_ctl #(.SERIAL(SER)) i_fuse_ctl (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rd_en = 1;
    @(posedge clk); #1 rd_en = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("R2 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    #400000;
    check("watchdog", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 rvalid low after reset", {31'b0, rvalid}, 32'h0);
    for (int i = 0; i < 15; i++)
      if (i != 6) rd(8'(i*4), 32'h0, "R1 reset value");
    rd(8'h18, 32'hFF, "R5 dout after reset");
    @(posedge clk); #1;
    @(negedge clk);
    check("R2 rvalid drops", {31'b0, rvalid}, 32'h0);
    #1;
    wr(8'h00, 32'hFFFF_FFFC);
    rd(8'h00, 32'h0000_03FC, "R3 address mask");
    for (int i = 1; i < 15; i++)
      if (i != 6) wr(8'(i*4), 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101));
    for (int i = 1; i < 15; i++)
      if (i != 6) rd(8'(i*4), 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101), "R8 readback");
    wr(8'h0C, 32'h1); wr(8'h1C, 32'h0); wr(8'h34, 32'h0);
    rd(8'h18, 32'hFF, "R5 only chip enable");
    wr(8'h1C, 32'h1);
    rd(8'h18, 32'hFF, "R5 trim off");
    wr(8'h34, 32'h1);
    rd(8'h18, 32'hFFFF_FFFF, "R4 R6 plain fuse at 0x3FC");
    wr(8'h00, 32'h0000_00FC);
    rd(8'h18, SER, "R4 R6 serial word");
    wr(8'h00, 32'h0000_00FD);
    rd(8'h18, ~SER, "R6 complement word");
    wr(8'h00, 32'h0000_0005);
    rd(8'h18, 32'hFFFF_FFFF, "R6 ordinary word");
    wr(8'h00, 32'h0000_04FC);
    rd(8'h18, SER, "R3 R6 masked address hits serial");
    wr(8'h0C, 32'hFFFF_FFFE);
    rd(8'h18, 32'hFF, "R10 chip enable bit0 clear");
    wr(8'h0C, 32'h1);
    wr(8'h34, 32'hFFFF_FFFE);
    rd(8'h18, 32'hFF, "R10 trim bit0 clear");
    wr(8'h34, 32'h1);
    wr(8'h18, 32'h1234_5678);
    rd(8'h18, SER, "R7 dout write ignored");
    wr(8'h1C, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'hFF, "R7 dout write ignored while gated");
    rd(8'h3C, 32'h0, "R9 read past last register");
    rd(8'hFC, 32'h0, "R9 read top offset");
    rd(8'h05, 32'h0, "R9 misaligned read");
    wr(8'h05, 32'hCAFE_F00D);
    wr(8'h3C, 32'hCAFE_F00D);
    rd(8'h04, 32'h1357_9BDF ^ 32'h0101_0101, "R9 misaligned write ignored");
    wr(8'h01, 32'h0000_0333);
    rd(8'h00, 32'h0000_04FC & 32'h3FF, "R9 misaligned address write ignored");
    repeat (4) @(posedge clk);
    #1;
    check("R2 all reads returned", 32'(exp_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule